// File: doc/BRIEF.md
# Residue-Number Nonlinear Counter Bank

This block holds sixteen short nonlinear feedback shift registers. Each one runs on its own cycle, and every cycle length is a different prime. Read as a set of residues, the sixteen registers form one counter whose joint period is the product of the sixteen primes. The joint state is never shown directly. A diffusion stage turns it into a 10-bit word on every step. Each bit of that word is the XOR of five counter outputs and one bit of the previous word. That registered word drives a downstream accumulator.

In hashing use, a byte can be injected on any advancing step. Each of its eight bits flips the feedback of one of the first eight counters. The same bits are also folded into the diffusion word, and the word's own feedback then carries them forward.

Top module: `rns_ctr_bank`

## Requirements
- R1: Counter k (k = 0..15) has n(k) stages, with n = 2,3,4,6,7,9,10,12,15,16,19,21,22,24,27,30. Starting from all-zero and with no injection, counter k returns to all-zero after exactly 2n(k)-1 advances: 3,5,7,11,13,17,19,23,29,31,37,41,43,47,53,59. Each of these periods is prime, and no two are equal.
- R2: While `rst` is high at a clock edge, every counter is cleared to zero and `dout` is cleared to 0.
- R3: At an edge where `adv` is low, `dout` and all counter state stay the same, whatever `inj_valid` and `inj_data` are.
- R4: At each advancing edge, `dout[j]` is loaded with the XOR of three terms: the output bits of counters (3j+7t) mod 16 for t = 0..4, the previous `dout[(j+1) mod 10]`, and `inj_valid & inj_data[j mod 8]`.
- R5: At an advancing edge with `inj_valid` high, bit i of `inj_data` (i = 0..7) is XORed into the feedback bit of counter i. Counters 8..15 never receive injected bits.
- R6: When `inj_valid` is low, `inj_data` has no effect on the counters or on `dout`.
- R7: A counter's output is its oldest stage. Each advance shifts the counter one place toward the oldest stage. The feedback bit enters the youngest stage and equals NOR(oldest, second oldest), before any injected bit is XORed in.
- R8: Every edge with `adv` high and `rst` low moves the counter bank exactly one step, and the joint counter state differs from its value before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset to the all-zero seed |
| adv | input | 1 | Advance enable; one step per edge while high |
| inj_valid | input | 1 | Hash byte present on this step |
| inj_data | input | 8 | Hash byte; bit i goes to counter i |
| dout | output | 10 | Registered diffused word |

## Verification
The bound checker watches every cycle. It checks that each counter returns to zero at exactly its prime period and at no earlier point, for as long as nothing has been injected since reset. It also checks that the whole state holds when `adv` is low, that each advance changes the joint state, and that reset clears everything. The tap pattern of the diffuser, its feedback rotation, and the way injected bytes reach the counters and the word are covered only by the bench. The bench compares `dout` on every clock against a queue-based reference while steps are held, while stray data is presented without `inj_valid`, and while hash bytes are injected.

// File: rtl/rns_ctr_pkg.sv
package rns_ctr_pkg;
    localparam int NUM_CNT = 16;
    localparam int OUT_W   = 10;
    localparam int INJ_W   = 8;
    localparam int TAPS    = 5;
    localparam int TAP_MUL = 3;
    localparam int TAP_STR = 7;

    // stage counts; period of counter k is 2*len-1 (all prime)
    localparam int CNT_LEN [NUM_CNT] = '{2, 3, 4, 6, 7, 9, 10, 12,
                                         15, 16, 19, 21, 22, 24, 27, 30};

    function automatic int cnt_off(input int idx);
        int s;
        s = 0;
        for (int k = 0; k < idx; k++) s += CNT_LEN[k];
        return s;
    endfunction

    function automatic int tap_idx(input int j, input int t);
        return (TAP_MUL * j + TAP_STR * t) % NUM_CNT;
    endfunction

    localparam int STATE_W = cnt_off(NUM_CNT);

    typedef struct packed {
        logic [STATE_W-1:0] cnt;
        logic [OUT_W-1:0]   dif;
    } bank_state_t;
endpackage

// File: rtl/rns_nlfsr_step.sv
module rns_nlfsr_step #(
    parameter int LEN = 4
) (
    input  logic [LEN-1:0] cur,
    input  logic           inj,
    output logic [LEN-1:0] nxt,
    output logic           msb
);
    logic fb;

    always_comb begin
        // NOR of the two oldest stages gives a single 2*LEN-1 cycle through zero
        fb  = ~(cur[LEN-1] | cur[LEN-2]) ^ inj;
        nxt = {cur[LEN-2:0], fb};
    end

    assign msb = cur[LEN-1];
endmodule

// File: rtl/rns_diffuser_step.sv
module rns_diffuser_step
    import rns_ctr_pkg::*;
(
    input  logic [NUM_CNT-1:0] msb,
    input  logic [OUT_W-1:0]   fb,
    input  logic               inj_valid,
    input  logic [INJ_W-1:0]   inj_data,
    output logic [OUT_W-1:0]   nxt
);
    always_comb begin
        nxt = '0;
        for (int j = 0; j < OUT_W; j++) begin
            nxt[j] = fb[(j + 1) % OUT_W] ^ (inj_valid & inj_data[j % INJ_W]);
            for (int t = 0; t < TAPS; t++) begin
                nxt[j] = nxt[j] ^ msb[tap_idx(j, t)];
            end
        end
    end
endmodule

// File: rtl/rns_ctr_bank.sv
module rns_ctr_bank
    import rns_ctr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic             inj_valid,
    input  logic [INJ_W-1:0] inj_data,
    output logic [OUT_W-1:0] dout
);
    bank_state_t        st_d, st_q;
    logic [NUM_CNT-1:0] msb;
    logic [NUM_CNT-1:0] inj_vec;
    logic [STATE_W-1:0] cnt_nxt;
    logic [OUT_W-1:0]   dif_nxt;
    logic [STATE_W-1:0] cnt_cur;

    always_comb begin
        inj_vec = '0;
        for (int i = 0; i < INJ_W; i++) inj_vec[i] = inj_valid & inj_data[i];
    end

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        localparam int OFF = cnt_off(g);
        localparam int LEN = CNT_LEN[g];
        rns_nlfsr_step #(.LEN(LEN)) u_step (
            .cur (st_q.cnt[OFF +: LEN]),
            .inj (inj_vec[g]),
            .nxt (cnt_nxt[OFF +: LEN]),
            .msb (msb[g])
        );
    end

    rns_diffuser_step u_dif (
        .msb       (msb),
        .fb        (st_q.dif),
        .inj_valid (inj_valid),
        .inj_data  (inj_data),
        .nxt       (dif_nxt)
    );

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d = '0;
        end else if (adv) begin
            st_d.cnt = cnt_nxt;
            st_d.dif = dif_nxt;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign dout    = st_q.dif;
    assign cnt_cur = st_q.cnt;
endmodule

// File: rtl/rns_ctr_bank_chk.sv
module rns_ctr_bank_chk
    import rns_ctr_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               adv,
    input logic               inj_valid,
    input logic [OUT_W-1:0]   dout,
    input logic [STATE_W-1:0] cnt_state
);
    logic rst_seen = 1'b0;
    logic dirty;

    always_ff @(posedge clk) begin
        if (rst) rst_seen <= 1'b1;
        if (rst) dirty <= 1'b0;
        else if (adv && inj_valid) dirty <= 1'b1;
    end

    a_r2_reset_clears: assert property (@(posedge clk) disable iff (rst)
        (rst_seen && $past(rst)) |-> (dout == '0 && cnt_state == '0));

    a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        (rst_seen && !$past(rst) && !$past(adv)) |-> ($stable(dout) && $stable(cnt_state)));

    a_r8_state_moves: assert property (@(posedge clk) disable iff (rst)
        (rst_seen && !$past(rst) && $past(adv)) |-> (cnt_state != $past(cnt_state)));

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_per
        localparam int OFF = cnt_off(g);
        localparam int LEN = CNT_LEN[g];
        localparam int PER = 2 * LEN - 1;
        logic [LEN-1:0] st;
        logic [7:0]     ph;

        assign st = cnt_state[OFF +: LEN];

        always_ff @(posedge clk) begin
            if (rst) ph <= '0;
            else if (adv) ph <= (ph == 8'(PER - 1)) ? 8'd0 : ph + 8'd1;
        end

        // R1: zero exactly at multiples of the prime period
        a_r1_prime_period: assert property (@(posedge clk) disable iff (rst)
            (rst_seen && !dirty) |-> ((st == '0) == (ph == 8'd0)));
    end
endmodule

bind rns_ctr_bank rns_ctr_bank_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .adv       (adv),
    .inj_valid (inj_valid),
    .dout      (dout),
    .cnt_state (cnt_cur)
);

// File: tb/rns_ctr_bank_bench.sv
module rns_ctr_bank_bench;
    localparam int NC = 16;
    localparam int LENS [NC] = '{2, 3, 4, 6, 7, 9, 10, 12, 15, 16, 19, 21, 22, 24, 27, 30};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       adv = 1'b0;
    logic       inj_valid = 1'b0;
    logic [7:0] inj_data = 8'h00;
    logic [9:0] dout;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;
    bit  mq [NC][$];
    bit [9:0] m_dif;

    rns_ctr_bank u_rns_ctr_bank (
        .clk(clk), .rst(rst), .adv(adv),
        .inj_valid(inj_valid), .inj_data(inj_data), .dout(dout)
    );

    always #2 clk = ~clk;

    task automatic model_reset();
        for (int i = 0; i < NC; i++) begin
            mq[i].delete();
            for (int s = 0; s < LENS[i]; s++) mq[i].push_back(1'b0);
        end
        m_dif = '0;
    endtask

    // front of each queue is the oldest stage (counter output)
    task automatic model_step(bit v, bit [7:0] d);
        bit [9:0] nd;
        bit fb;
        for (int j = 0; j < 10; j++) begin
            nd[j] = m_dif[(j + 1) % 10] ^ (v & d[j % 8]);
            for (int t = 0; t < 5; t++) nd[j] = nd[j] ^ mq[(3 * j + 7 * t) % NC][0];
        end
        for (int i = 0; i < NC; i++) begin
            fb = !(mq[i][0] | mq[i][1]);
            if (v && i < 8) fb = fb ^ d[i];
            void'(mq[i].pop_front());
            mq[i].push_back(fb);
        end
        m_dif = nd;
    endtask

    task automatic check(string tag);
        n_vec++;
        if (dout !== m_dif) begin
            n_bad++;
            $display("FAIL %s: dout=%h expected=%h at %0t", tag, dout, m_dif, $time);
        end
    endtask

    task automatic cyc(bit r, bit a, bit v, bit [7:0] d, string tag);
        rst = r; adv = a; inj_valid = v; inj_data = d;
        if (r) model_reset();
        else if (a) model_step(v, d);
        @(posedge clk); #1;
        check(tag);
        @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R2: reset state
        cyc(1, 0, 0, 8'h00, "R2");
        cyc(1, 1, 1, 8'hFF, "R2");
        // R1 R4 R7 R8: free run across many joint periods of small counters
        for (int k = 0; k < 2500; k++) cyc(0, 1, 0, 8'h00, "R1");
        // R3 R6: holds and stray data without valid
        for (int k = 0; k < 600; k++)
            cyc(0, (k % 3) != 0, 0, 8'(k * 29 + 3), (k % 3) != 0 ? "R6" : "R3");
        // R5 R4: hashing with injected bytes
        for (int k = 0; k < 400; k++) cyc(0, 1, 1, 8'(k * 37 + 5), "R5");
        // R3: idle with valid data presented
        for (int k = 0; k < 20; k++) cyc(0, 0, 1, 8'(k * 11 + 1), "R3");
        // R2: mid-run reset, then R7 R8 from seed
        cyc(1, 1, 0, 8'h00, "R2");
        for (int k = 0; k < 300; k++) cyc(0, 1, 0, 8'h00, "R7");
        // R5: single-bit injections, one counter at a time
        for (int k = 0; k < 64; k++) cyc(0, 1, (k % 2) == 0, 8'(1 << (k % 8)), "R5");
        for (int k = 0; k < 200; k++) cyc(0, 1, (k % 5) == 0, 8'(k * 13), "R4");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule